// File: doc/BRIEF.md
# Gate Driver Fault Response Manager

This block sits between the PWM generator and the six gate outputs of a three-phase bridge. Each phase has a high-side and a low-side PWM input. The block also takes one overcurrent detect flag for each FET and a single gate-level overtemperature detect. From these it decides which gates may follow their PWM inputs. It also drives two active-low pins: a hard fault pin and a warning pin. A status field records which phases saw an overcurrent.

The overtemperature detect always shuts the whole bridge down, drops the charge-pump enable and latches. The response to an overcurrent depends on a 2-bit policy field. One policy turns off only the tripped FET until its next PWM turn-on. Another latches the whole phase off. A third only reports the event, and the last setting disables overcurrent handling. Latched faults and status bits stay set until the enable/reset controller pulses a clear strobe.

Top module: `gate_fault_mgr`

## Requirements
- R1: After reset, every gate output equals 0 while its PWM input is 0, fault_n, warn_n and cp_en are 1, and oc_status and ot_status are 0.
- R2: Once ot_det has been sampled high on a clock edge, all gate outputs are 0 and cp_en is 0 until a clear, whatever the PWM inputs are.
- R3: After ot_det is sampled, fault_n and warn_n are both 0 and ot_status is 1.
- R4: With oc_mode = 2'b00 (cycle limit), an overcurrent on a FET turns off only that FET from the next cycle. The FET stays off until the cycle in which its PWM input rises, and follows the PWM input from that cycle on. This mode latches nothing and leaves fault_n at 1.
- R5: With oc_mode = 2'b01 (latch), an overcurrent on either FET of a phase forces both of that phase's gates to 0 regardless of PWM, latches, and drives fault_n to 0.
- R6: With oc_mode = 2'b10 (report), overcurrents leave every gate equal to its PWM input and fault_n at 1.
- R7: In modes 00, 01 and 10, an overcurrent on phase p sets bit p of oc_status. warn_n is 0 whenever any oc_status bit or ot_status is 1.
- R8: With oc_mode = 2'b11 (off), overcurrent detects change neither the gates nor oc_status.
- R9: A clear pulse on clr empties the latched faults and both status fields on that edge. A detect that is still high sets them again on the following edge.
- R10: fault_n, warn_n and cp_en are registered: a detect changes them only at the next rising clock edge, never within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear strobe for latched faults and status |
| oc_mode | input | 2 | Overcurrent policy: 00 limit, 01 latch, 10 report, 11 off |
| pwm_hi | input | 3 | High-side PWM command, bit per phase |
| pwm_lo | input | 3 | Low-side PWM command, bit per phase |
| oc_hi | input | 3 | High-side FET overcurrent detect, bit per phase |
| oc_lo | input | 3 | Low-side FET overcurrent detect, bit per phase |
| ot_det | input | 1 | Gate driver overtemperature detect |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| cp_en | output | 1 | Charge-pump enable |
| fault_n | output | 1 | Active-low hard fault pin |
| warn_n | output | 1 | Active-low warning pin |
| oc_status | output | 3 | Phases that saw an overcurrent |
| ot_status | output | 1 | Overtemperature recorded |

## Verification
The bench builds the block with the default of three phases, so the per-phase generate loop produces every instance it would in the real bridge. With that width, random detect patterns can trip one, two or all three phases in the same cycle. A tripped phase can then be checked against neighbours that must keep following their PWM. Policy changes in the middle of a run, with limit state still pending, also fall within reach.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    typedef enum logic [1:0] {
        OC_LIMIT  = 2'b00,
        OC_LATCH  = 2'b01,
        OC_REPORT = 2'b10,
        OC_OFF    = 2'b11
    } oc_mode_e;

    // per-phase fault state
    typedef struct packed {
        logic lim_hi;
        logic lim_lo;
        logic latched;
        logic seen;
    } phase_state_t;

    function automatic logic records_oc(input oc_mode_e m);
        return m != OC_OFF;
    endfunction

endpackage

// File: rtl/gfm_phase.sv
module gfm_phase
    import gfm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  oc_mode_e mode,
    input  logic     ot_q,
    input  logic     pwm_hi,
    input  logic     pwm_lo,
    input  logic     oc_hi,
    input  logic     oc_lo,
    output logic     gate_hi,
    output logic     gate_lo,
    output logic     latched_q,
    output logic     latched_nx,
    output logic     seen_q,
    output logic     seen_nx
);
    phase_state_t st_q, st_nx;
    logic pwm_hi_d, pwm_lo_d;
    logic rise_hi, rise_lo, oc_any;

    assign rise_hi = pwm_hi & ~pwm_hi_d;
    assign rise_lo = pwm_lo & ~pwm_lo_d;
    assign oc_any  = oc_hi | oc_lo;

    always_comb begin
        st_nx.lim_hi  = ((mode == OC_LIMIT) & oc_hi) | (st_q.lim_hi & ~rise_hi);
        st_nx.lim_lo  = ((mode == OC_LIMIT) & oc_lo) | (st_q.lim_lo & ~rise_lo);
        st_nx.latched = clr ? 1'b0 : (st_q.latched | ((mode == OC_LATCH) & oc_any));
        st_nx.seen    = clr ? 1'b0 : (st_q.seen | (records_oc(mode) & oc_any));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            pwm_hi_d <= 1'b0;
            pwm_lo_d <= 1'b0;
        end else begin
            st_q     <= st_nx;
            pwm_hi_d <= pwm_hi;
            pwm_lo_d <= pwm_lo;
        end
    end

    assign gate_hi = pwm_hi & ~ot_q & ~st_q.latched & ~(st_q.lim_hi & ~rise_hi);
    assign gate_lo = pwm_lo & ~ot_q & ~st_q.latched & ~(st_q.lim_lo & ~rise_lo);

    assign latched_q  = st_q.latched;
    assign latched_nx = st_nx.latched;
    assign seen_q     = st_q.seen;
    assign seen_nx    = st_nx.seen;

    // R5
    latch_blocks_phase_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.latched |-> (!gate_hi && !gate_lo));

    // R4
    limit_holds_off_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.lim_hi && !rise_hi) |-> !gate_hi);

    // R9
    clear_empties_latch_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !st_q.latched);

endmodule

// File: rtl/gfm_pins.sv
module gfm_pins (
    input  logic clk,
    input  logic rst,
    input  logic ot_nx,
    input  logic any_latched_nx,
    input  logic any_seen_nx,
    output logic fault_n,
    output logic warn_n,
    output logic cp_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fault_n <= 1'b1;
            warn_n  <= 1'b1;
            cp_en   <= 1'b1;
        end else begin
            fault_n <= ~(ot_nx | any_latched_nx);
            warn_n  <= ~(ot_nx | any_seen_nx);
            cp_en   <= ~ot_nx;
        end
    end

    // R10
    fault_only_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !any_latched_nx && !ot_nx |=> fault_n);

endmodule

// File: rtl/gate_fault_mgr.sv
module gate_fault_mgr
    import gfm_pkg::*;
#(
    parameter int NUM_PH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [1:0]        oc_mode,
    input  logic [NUM_PH-1:0] pwm_hi,
    input  logic [NUM_PH-1:0] pwm_lo,
    input  logic [NUM_PH-1:0] oc_hi,
    input  logic [NUM_PH-1:0] oc_lo,
    input  logic              ot_det,
    output logic [NUM_PH-1:0] gate_hi,
    output logic [NUM_PH-1:0] gate_lo,
    output logic              cp_en,
    output logic              fault_n,
    output logic              warn_n,
    output logic [NUM_PH-1:0] oc_status,
    output logic              ot_status
);
    oc_mode_e          mode;
    logic              ot_q, ot_nx;
    logic [NUM_PH-1:0] lat_q, lat_nx, seen_nx;

    assign mode  = oc_mode_e'(oc_mode);
    assign ot_nx = clr ? 1'b0 : (ot_q | ot_det);

    always_ff @(posedge clk) begin
        if (rst) ot_q <= 1'b0;
        else     ot_q <= ot_nx;
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
        gfm_phase u_ph (
            .clk        (clk),
            .rst        (rst),
            .clr        (clr),
            .mode       (mode),
            .ot_q       (ot_q),
            .pwm_hi     (pwm_hi[p]),
            .pwm_lo     (pwm_lo[p]),
            .oc_hi      (oc_hi[p]),
            .oc_lo      (oc_lo[p]),
            .gate_hi    (gate_hi[p]),
            .gate_lo    (gate_lo[p]),
            .latched_q  (lat_q[p]),
            .latched_nx (lat_nx[p]),
            .seen_q     (oc_status[p]),
            .seen_nx    (seen_nx[p])
        );
    end

    gfm_pins u_pins (
        .clk            (clk),
        .rst            (rst),
        .ot_nx          (ot_nx),
        .any_latched_nx (|lat_nx),
        .any_seen_nx    (|seen_nx),
        .fault_n        (fault_n),
        .warn_n         (warn_n),
        .cp_en          (cp_en)
    );

    assign ot_status = ot_q;

    // R2
    ot_gates_off_chk: assert property (@(posedge clk) disable iff (rst)
        ot_q |-> (gate_hi == '0 && gate_lo == '0));

    // R3
    ot_pins_low_chk: assert property (@(posedge clk) disable iff (rst)
        ot_q |-> (!fault_n && !warn_n && !cp_en));

    // R7
    status_warns_chk: assert property (@(posedge clk) disable iff (rst)
        (|oc_status) |-> !warn_n);

    // R5
    latch_pulls_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (|lat_q) |-> !fault_n);

endmodule

// File: tb/gate_fault_mgr_test.sv
module gate_fault_mgr_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic [1:0] oc_mode = 2'b00;
    logic [2:0] pwm_hi = '0, pwm_lo = '0, oc_hi = '0, oc_lo = '0;
    logic       ot_det = 1'b0;
    logic [2:0] gate_hi, gate_lo, oc_status;
    logic       cp_en, fault_n, warn_n, ot_status;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic       m_ot;
    logic [2:0] m_lat, m_lh, m_ll, m_st, m_pdh, m_pdl;

    always #5 clk = ~clk;

    gate_fault_mgr uut (
        .clk(clk), .rst(rst), .clr(clr), .oc_mode(oc_mode),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .oc_hi(oc_hi), .oc_lo(oc_lo),
        .ot_det(ot_det), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .cp_en(cp_en), .fault_n(fault_n), .warn_n(warn_n),
        .oc_status(oc_status), .ot_status(ot_status)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_gate(input logic [2:0] pwm, input logic [2:0] lim,
                                            input logic [2:0] pd);
        return pwm & ~{3{m_ot}} & ~m_lat & ~(lim & ~(pwm & ~pd));
    endfunction

    function automatic string mode_tag();
        case (oc_mode)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic model_reset();
        m_ot = 0; m_lat = 0; m_lh = 0; m_ll = 0; m_st = 0; m_pdh = 0; m_pdl = 0;
    endtask

    // inputs already driven after a falling edge
    task automatic cycle();
        logic       n_ot;
        logic [2:0] n_lat, n_lh, n_ll, n_st;
        #1;
        chk({mode_tag(), " R2 gate_hi"}, {5'b0, gate_hi}, {5'b0, exp_gate(pwm_hi, m_lh, m_pdh)});
        chk({mode_tag(), " R2 gate_lo"}, {5'b0, gate_lo}, {5'b0, exp_gate(pwm_lo, m_ll, m_pdl)});
        n_lh  = ((oc_mode == 2'b00) ? oc_hi : 3'b0) | (m_lh & ~(pwm_hi & ~m_pdh));
        n_ll  = ((oc_mode == 2'b00) ? oc_lo : 3'b0) | (m_ll & ~(pwm_lo & ~m_pdl));
        n_lat = clr ? 3'b0 : (m_lat | ((oc_mode == 2'b01) ? (oc_hi | oc_lo) : 3'b0));
        n_st  = clr ? 3'b0 : (m_st | ((oc_mode != 2'b11) ? (oc_hi | oc_lo) : 3'b0));
        n_ot  = clr ? 1'b0 : (m_ot | ot_det);
        @(posedge clk);
        m_lh = n_lh; m_ll = n_ll; m_lat = n_lat; m_st = n_st; m_ot = n_ot;
        m_pdh = pwm_hi; m_pdl = pwm_lo;
        #1;
        chk("R3 R5 fault_n", {7'b0, fault_n}, {7'b0, ~(m_ot | (|m_lat))});
        chk("R7 warn_n", {7'b0, warn_n}, {7'b0, ~(m_ot | (|m_st))});
        chk("R2 cp_en", {7'b0, cp_en}, {7'b0, ~m_ot});
        chk("R7 oc_status", {5'b0, oc_status}, {5'b0, m_st});
        chk("R3 ot_status", {7'b0, ot_status}, {7'b0, m_ot});
        @(negedge clk);
    endtask

    task automatic quiet();
        clr = 0; oc_hi = 0; oc_lo = 0; ot_det = 0;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        #1;
        chk("R1 fault_n", {7'b0, fault_n}, 8'd1);
        chk("R1 warn_n", {7'b0, warn_n}, 8'd1);
        chk("R1 cp_en", {7'b0, cp_en}, 8'd1);
        chk("R1 status", {4'b0, ot_status, oc_status}, 8'd0);
        chk("R1 gates", {2'b0, gate_hi, gate_lo}, 8'd0);
        @(negedge clk);

        // R4: limit on phase 1 high side, other FETs keep following
        oc_mode = 2'b00; pwm_hi = 3'b111; pwm_lo = 3'b000;
        cycle();
        oc_hi = 3'b010;
        cycle();
        oc_hi = 0;
        #1 chk("R4 limit off", {5'b0, gate_hi}, 8'b101);
        cycle();
        pwm_hi = 3'b101; cycle();
        pwm_hi = 3'b111;
        #1 chk("R4 rise restores", {5'b0, gate_hi}, 8'b111);
        chk("R4 fault_n high", {7'b0, fault_n}, 8'd1);
        cycle();

        // R10: latch-mode detect does not reach fault_n before the edge
        clr = 1; cycle(); clr = 0;
        oc_mode = 2'b01; pwm_lo = 3'b111; oc_lo = 3'b001;
        #1 chk("R10 same cycle", {7'b0, fault_n}, 8'd1);
        cycle();
        oc_lo = 0;
        #1 chk("R5 phase off", {2'b0, gate_hi, gate_lo}, {2'b0, 3'b110, 3'b110});
        cycle();

        // R9: clear with detect still high re-sets next edge
        oc_lo = 3'b001; clr = 1;
        cycle();
        chk("R9 cleared", {5'b0, oc_status}, 8'd0);
        clr = 0;
        cycle();
        chk("R9 re-set", {5'b0, oc_status}, 8'd1);
        quiet(); clr = 1; cycle(); clr = 0;

        // R8: off mode ignores detects
        oc_mode = 2'b11; oc_hi = 3'b111; oc_lo = 3'b111;
        cycle(); cycle();
        quiet();
        #1 chk("R8 gates follow", {2'b0, gate_hi, gate_lo}, 8'h3f);
        chk("R8 no status", {5'b0, oc_status}, 8'd0);
        cycle();

        // R6: report mode
        oc_mode = 2'b10; oc_hi = 3'b100; cycle(); quiet();
        #1 chk("R6 gates follow", {2'b0, gate_hi, gate_lo}, 8'h3f);
        chk("R7 phase 2 recorded", {5'b0, oc_status}, 8'b100);
        cycle();

        // R2 overtemperature
        ot_det = 1; cycle(); ot_det = 0;
        #1 chk("R2 all off", {2'b0, gate_hi, gate_lo}, 8'd0);
        cycle();
        clr = 1; cycle(); clr = 0;

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 50) == 0) oc_mode = 2'($urandom);
            pwm_hi = 3'($urandom); pwm_lo = 3'($urandom);
            oc_hi  = (($urandom % 8) == 0) ? 3'($urandom) : 3'b0;
            oc_lo  = (($urandom % 8) == 0) ? 3'($urandom) : 3'b0;
            ot_det = (($urandom % 300) == 0);
            clr    = (($urandom % 40) == 0);
            cycle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule